// File: doc/BRIEF.md
# Chunked Local-Memory Load DMA Engine

This block fills the instruction or data RAM of an embedded controller from an external memory. Software sets up the transfer through a small register file: the external base address in 256-byte units, split across a low and a high word; an external source offset; a local destination offset; and a sideband configuration word. Writing the command register then starts exactly one 256-byte transfer.

The engine issues 32-bit read requests on a valid/ready port. Each request carries the aperture, addressing-type and no-context sideband. Responses come back in order, and the engine writes each one into the RAM that the command selected, together with the command's secure flag. Writes to instruction RAM also carry the chunk's source offset as a page tag. The command register reads back an idle bit and a sticky error bit. A command that cannot run is dropped and raises the error bit. A strobe register clears the error and puts the control word back to its default.

Top module: `mld_dma`

## Requirements
- R1: After reset the command register reads idle=1 (bit 0) and error=0 (bit 1), no read request is valid and neither RAM write strobe is high.
- R2: A command whose size code (bits 3:0) is 6 produces exactly 64 read requests. Request k is at byte address {high base[15:0], low base[31:0], 8'h00} + source offset + 4k, and the requests come in increasing k. No more than MAX_OUT requests are outstanding at once.
- R3: The n-th response is written to local byte address (destination offset with bits 7:0 cleared) + 4n. The instruction RAM strobe is used when command bit 4 is 1 and the data RAM strobe when it is 0. The two strobes are never high together.
- R4: Every write of a chunk carries the command's secure flag (bit 5) on lmem_sec.
- R5: Instruction RAM writes carry the chunk's source offset on lmem_tag. Data RAM writes carry zero.
- R6: Idle reads 0 from the cycle after an accepted command write. It returns to 1 in the cycle in which the 64th write strobe is presented, not before.
- R7: A command with a size code other than 6 starts nothing: no request is issued, idle stays 1 and the error bit is set.
- R8: A command written while a chunk is in progress is dropped and sets the error bit. The running chunk completes with its original target and addresses.
- R9: The configuration register (word 5) holds the aperture in bits 1:0 (0 local, 1 coherent system, 2 non-coherent system) and physical addressing in bit 2. Both appear on every request. With aperture code 3 a command is dropped and sets the error bit.
- R10: Control register (word 6) bit 0 permits physical access without a context and drives ext_req_noctx. Writing 1 to bit 0 of word 7 returns the control register to 0 and clears the error bit.
- R11: A read request that is not accepted stays valid with an unchanged address until the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 base low, 1 base high, 2 local offset, 3 source offset, 4 command, 5 config, 6 control, 7 DMA reset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ext_req_valid | output | 1 | External read request valid |
| ext_req_ready | input | 1 | External read request accepted |
| ext_req_addr | output | 56 | External byte address |
| ext_req_target | output | 2 | Aperture sideband |
| ext_req_phys | output | 1 | Physical (1) or virtual (0) addressing |
| ext_req_noctx | output | 1 | Physical access without context permitted |
| ext_rsp_valid | input | 1 | Read response valid, in request order |
| ext_rsp_data | input | 32 | Read response data |
| lmem_imem_we | output | 1 | Instruction RAM write strobe |
| lmem_dmem_we | output | 1 | Data RAM write strobe |
| lmem_addr | output | 16 | Local RAM byte address |
| lmem_wdata | output | 32 | Local RAM write data |
| lmem_sec | output | 1 | Secure flag stored with the word |
| lmem_tag | output | 32 | Page tag for instruction RAM writes |

## Verification
The embedded assertions watch the local invariants on every cycle: the two RAM strobes are exclusive, a stalled request holds still, in-flight requests stay within the limit, idle returns only together with a final write strobe, and a rejected or busy command raises the error bit. Whether the addresses, data ordering, tags and sideband are correct over a whole chunk can only be shown by the bench's scenarios. Those scenarios compare every request and every write against values computed from the programmed registers, under varying ready and response patterns, and also cover the reset-strobe behaviour.

// File: rtl/mld_pkg.sv
package mld_pkg;
   localparam int EXT_AW = 56;

   typedef enum logic [2:0] {
      RA_BASE_LO = 3'd0,
      RA_BASE_HI = 3'd1,
      RA_LOFFS   = 3'd2,
      RA_XOFFS   = 3'd3,
      RA_CMD     = 3'd4,
      RA_XCFG    = 3'd5,
      RA_CTL     = 3'd6,
      RA_DRST    = 3'd7
   } reg_addr_e;

   typedef enum logic [1:0] {
      AP_LOCAL  = 2'd0,
      AP_COH    = 2'd1,
      AP_NONCOH = 2'd2,
      AP_BAD    = 2'd3
   } aperture_e;

   typedef struct packed {
      logic       sec;
      logic       imem;
      logic [3:0] size;
   } cmd_t;
endpackage

// File: rtl/mld_regs.sv
module mld_regs
   import mld_pkg::*;
#(
   parameter int LADDR_W   = 16,
   parameter int XOFF_W    = 32,
   parameter int SIZE_CODE = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [2:0]         addr,
   input  logic [31:0]        wdata,
   input  logic               busy,
   output logic [31:0]        rdata,
   output logic               start,
   output logic [EXT_AW-1:0]  base_addr,
   output logic [LADDR_W-1:0] loffs,
   output logic [XOFF_W-1:0]  xoffs,
   output logic               sel_imem,
   output logic               sec,
   output logic [1:0]         target,
   output logic               phys,
   output logic               noctx
);
   if (LADDR_W > 32 || XOFF_W > 32) begin : g_bad_width
      $error("offset registers must fit a 32-bit word");
   end

   logic [31:0]        base_lo_q;
   logic [15:0]        base_hi_q;
   logic [LADDR_W-1:0] loffs_q;
   logic [XOFF_W-1:0]  xoffs_q;
   logic [1:0]         target_q;
   logic               phys_q;
   logic               noctx_q;
   logic               err_q;
   cmd_t               cmd_w;
   logic               cmd_wr;
   logic               drst_wr;

   assign cmd_w   = cmd_t'(wdata[5:0]);
   assign cmd_wr  = we && (addr == RA_CMD);
   assign drst_wr = we && (addr == RA_DRST) && wdata[0];
   assign start   = cmd_wr && !busy && (cmd_w.size == 4'(SIZE_CODE))
                    && (target_q != AP_BAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_lo_q <= '0;
         base_hi_q <= '0;
         loffs_q   <= '0;
         xoffs_q   <= '0;
         target_q  <= AP_LOCAL;
         phys_q    <= 1'b0;
         noctx_q   <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         if (we) begin
            case (addr)
               RA_BASE_LO: base_lo_q <= wdata;
               RA_BASE_HI: base_hi_q <= wdata[15:0];
               RA_LOFFS:   loffs_q   <= wdata[LADDR_W-1:0];
               RA_XOFFS:   xoffs_q   <= wdata[XOFF_W-1:0];
               RA_XCFG: begin
                  target_q <= wdata[1:0];
                  phys_q   <= wdata[2];
               end
               RA_CTL:     noctx_q   <= wdata[0];
               default: ;
            endcase
         end
         if (cmd_wr && !start) err_q <= 1'b1;
         if (drst_wr) begin
            noctx_q <= 1'b0;
            err_q   <= 1'b0;
         end
      end
   end

   always_comb begin
      case (addr)
         RA_BASE_LO: rdata = base_lo_q;
         RA_BASE_HI: rdata = {16'h0, base_hi_q};
         RA_LOFFS:   rdata = 32'(loffs_q);
         RA_XOFFS:   rdata = 32'(xoffs_q);
         RA_CMD:     rdata = {30'h0, err_q, !busy};
         RA_XCFG:    rdata = {29'h0, phys_q, target_q};
         RA_CTL:     rdata = {31'h0, noctx_q};
         default:    rdata = 32'h0;
      endcase
   end

   assign base_addr = {base_hi_q, base_lo_q, 8'h00};
   assign loffs     = loffs_q;
   assign xoffs     = xoffs_q;
   assign sel_imem  = cmd_w.imem;
   assign sec       = cmd_w.sec;
   assign target    = target_q;
   assign phys      = phys_q;
   assign noctx     = noctx_q;

   AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == RA_CMD && busy) |=> err_q);  // R8
   AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == RA_CMD && wdata[3:0] != 4'(SIZE_CODE)) |=> err_q);  // R7
   AST_BAD_APERTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && target_q == AP_BAD) |=> err_q);  // R9
endmodule

// File: rtl/mld_seq.sv
module mld_seq
   import mld_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CHUNK_BYTES = 256,
   parameter int LADDR_W     = 16,
   parameter int XOFF_W      = 32,
   parameter int MAX_OUT     = 4,
   parameter bit TAG_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [EXT_AW-1:0]  base_addr,
   input  logic [LADDR_W-1:0] loffs,
   input  logic [XOFF_W-1:0]  xoffs,
   input  logic               sel_imem,
   input  logic               sec,
   output logic               busy,
   output logic               ext_req_valid,
   input  logic               ext_req_ready,
   output logic [EXT_AW-1:0]  ext_req_addr,
   input  logic               ext_rsp_valid,
   input  logic [DATA_W-1:0]  ext_rsp_data,
   output logic               lmem_imem_we,
   output logic               lmem_dmem_we,
   output logic [LADDR_W-1:0] lmem_addr,
   output logic [DATA_W-1:0]  lmem_wdata,
   output logic               lmem_sec,
   output logic [XOFF_W-1:0]  lmem_tag
);
   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int BEATS      = CHUNK_BYTES / BEAT_BYTES;
   localparam int CW         = $clog2(BEATS + 1);
   localparam int ALIGN      = $clog2(CHUNK_BYTES);
   localparam int BSH        = $clog2(BEAT_BYTES);
   localparam logic [LADDR_W-1:0] DST_MASK = ~LADDR_W'(CHUNK_BYTES - 1);

   if (DATA_W % 8 != 0 || (1 << BSH) != BEAT_BYTES) begin : g_bad_dw
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if ((1 << ALIGN) != CHUNK_BYTES || CHUNK_BYTES < BEAT_BYTES) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a power of two of at least one beat");
   end
   if (MAX_OUT < 1 || MAX_OUT > BEATS) begin : g_bad_out
      $error("MAX_OUT must lie between 1 and the beats per chunk");
   end
   if (LADDR_W <= ALIGN || LADDR_W < CW) begin : g_bad_laddr
      $error("LADDR_W too narrow for one chunk");
   end

   logic               busy_q;
   logic [CW-1:0]      iss_q, rcv_q, outstanding;
   logic [EXT_AW-1:0]  src_q;
   logic [LADDR_W-1:0] dst_q;
   logic               imem_q, sec_q;
   logic               take, last, fire;
   logic               wr_i_q, wr_d_q, wr_sec_q;
   logic [LADDR_W-1:0] wr_addr_q;
   logic [DATA_W-1:0]  wr_data_q;

   assign outstanding   = iss_q - rcv_q;
   assign ext_req_valid = busy_q && (iss_q < CW'(BEATS)) && (outstanding < CW'(MAX_OUT));
   assign ext_req_addr  = src_q + (EXT_AW'(iss_q) << BSH);
   assign fire          = ext_req_valid && ext_req_ready;
   assign take          = busy_q && ext_rsp_valid;
   assign last          = take && (rcv_q == CW'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         iss_q     <= '0;
         rcv_q     <= '0;
         src_q     <= '0;
         dst_q     <= '0;
         imem_q    <= 1'b0;
         sec_q     <= 1'b0;
         wr_i_q    <= 1'b0;
         wr_d_q    <= 1'b0;
         wr_sec_q  <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
      end else begin
         wr_i_q <= take && imem_q;
         wr_d_q <= take && !imem_q;
         if (start && !busy_q) begin
            busy_q <= 1'b1;
            iss_q  <= '0;
            rcv_q  <= '0;
            src_q  <= base_addr + EXT_AW'(xoffs);
            dst_q  <= loffs & DST_MASK;
            imem_q <= sel_imem;
            sec_q  <= sec;
         end else begin
            if (fire) iss_q <= iss_q + 1'b1;
            if (take) begin
               rcv_q     <= rcv_q + 1'b1;
               wr_addr_q <= dst_q + (LADDR_W'(rcv_q) << BSH);
               wr_data_q <= ext_rsp_data;
               wr_sec_q  <= sec_q;
            end
            if (last) busy_q <= 1'b0;
         end
      end
   end

   if (TAG_EN) begin : g_tag
      logic [XOFF_W-1:0] tag_q, tag_out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q     <= '0;
            tag_out_q <= '0;
         end else begin
            if (start && !busy_q) tag_q <= xoffs;
            tag_out_q <= (take && imem_q) ? tag_q : '0;
         end
      end
      assign lmem_tag = tag_out_q;
   end else begin : g_no_tag
      assign lmem_tag = '0;
   end

   assign busy         = busy_q;
   assign lmem_imem_we = wr_i_q;
   assign lmem_dmem_we = wr_d_q;
   assign lmem_addr    = wr_addr_q;
   assign lmem_wdata   = wr_data_q;
   assign lmem_sec     = wr_sec_q;

   AST_ONE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      !(lmem_imem_we && lmem_dmem_we));  // R3
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req_valid && !ext_req_ready) |=> (ext_req_valid && $stable(ext_req_addr)));  // R11
   AST_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding <= CW'(MAX_OUT));  // R2
   AST_IDLE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (lmem_imem_we || lmem_dmem_we));  // R6
endmodule

// File: rtl/mld_dma.sv
module mld_dma
   import mld_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CHUNK_BYTES = 256,
   parameter int LADDR_W     = 16,
   parameter int XOFF_W      = 32,
   parameter int MAX_OUT     = 4,
   parameter bit TAG_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [2:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               ext_req_valid,
   input  logic               ext_req_ready,
   output logic [EXT_AW-1:0]  ext_req_addr,
   output logic [1:0]         ext_req_target,
   output logic               ext_req_phys,
   output logic               ext_req_noctx,
   input  logic               ext_rsp_valid,
   input  logic [DATA_W-1:0]  ext_rsp_data,
   output logic               lmem_imem_we,
   output logic               lmem_dmem_we,
   output logic [LADDR_W-1:0] lmem_addr,
   output logic [DATA_W-1:0]  lmem_wdata,
   output logic               lmem_sec,
   output logic [XOFF_W-1:0]  lmem_tag
);
   localparam int SIZE_CODE = $clog2(CHUNK_BYTES) - 2;

   logic               busy, start, sel_imem, sec;
   logic [EXT_AW-1:0]  base_addr;
   logic [LADDR_W-1:0] loffs;
   logic [XOFF_W-1:0]  xoffs;

   mld_regs #(
      .LADDR_W  (LADDR_W),
      .XOFF_W   (XOFF_W),
      .SIZE_CODE(SIZE_CODE)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .busy     (busy),
      .rdata    (reg_rdata),
      .start    (start),
      .base_addr(base_addr),
      .loffs    (loffs),
      .xoffs    (xoffs),
      .sel_imem (sel_imem),
      .sec      (sec),
      .target   (ext_req_target),
      .phys     (ext_req_phys),
      .noctx    (ext_req_noctx)
   );

   mld_seq #(
      .DATA_W     (DATA_W),
      .CHUNK_BYTES(CHUNK_BYTES),
      .LADDR_W    (LADDR_W),
      .XOFF_W     (XOFF_W),
      .MAX_OUT    (MAX_OUT),
      .TAG_EN     (TAG_EN)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .base_addr    (base_addr),
      .loffs        (loffs),
      .xoffs        (xoffs),
      .sel_imem     (sel_imem),
      .sec          (sec),
      .busy         (busy),
      .ext_req_valid(ext_req_valid),
      .ext_req_ready(ext_req_ready),
      .ext_req_addr (ext_req_addr),
      .ext_rsp_valid(ext_rsp_valid),
      .ext_rsp_data (ext_rsp_data),
      .lmem_imem_we (lmem_imem_we),
      .lmem_dmem_we (lmem_dmem_we),
      .lmem_addr    (lmem_addr),
      .lmem_wdata   (lmem_wdata),
      .lmem_sec     (lmem_sec),
      .lmem_tag     (lmem_tag)
   );

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);  // R6
endmodule

// File: tb/mld_dma_test.sv
module mld_dma_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd4;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ext_req_valid, ext_req_ready = 1'b0;
   logic [55:0] ext_req_addr;
   logic [1:0]  ext_req_target;
   logic        ext_req_phys, ext_req_noctx;
   logic        ext_rsp_valid = 1'b0;
   logic [31:0] ext_rsp_data = '0;
   logic        lmem_imem_we, lmem_dmem_we, lmem_sec;
   logic [15:0] lmem_addr;
   logic [31:0] lmem_wdata, lmem_tag;

   int nchk = 0, nerr = 0, cyc = 0;
   int rdy_mode = 0, rsp_mode = 0;
   int nreq = 0, rp = 0, nwr = 0, sb_bad = 0;
   logic [1:0]  exp_tgt;
   logic        exp_phys, exp_noctx;
   logic [55:0] reqlog [0:255];
   logic [15:0] wa [0:255];
   logic [31:0] wd [0:255], wt [0:255];
   logic        ws [0:255], wi [0:255], widle [0:255], wboth [0:255];

   mld_dma uut (.*);

   always #4 clk = ~clk;

   function automatic logic [31:0] fdat(input logic [55:0] a);
      return a[31:0] ^ {a[55:40], 16'h5A3C};
   endfunction

   // external memory model and write monitor, all at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (lmem_imem_we || lmem_dmem_we) begin
         if (nwr < 256) begin
            wa[nwr] = lmem_addr; wd[nwr] = lmem_wdata; wt[nwr] = lmem_tag;
            ws[nwr] = lmem_sec; wi[nwr] = lmem_imem_we;
            wboth[nwr] = lmem_imem_we && lmem_dmem_we;
            widle[nwr] = reg_rdata[0];
         end
         nwr++;
      end
      if (rp < nreq && (rsp_mode == 0 || cyc[0])) begin
         ext_rsp_valid = 1'b1; ext_rsp_data = fdat(reqlog[rp]); rp++;
      end else begin
         ext_rsp_valid = 1'b0;
      end
      ext_req_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 3 == 0);
      if (ext_req_valid && ext_req_ready) begin
         if (nreq < 256) reqlog[nreq] = ext_req_addr;
         if (ext_req_target != exp_tgt || ext_req_phys != exp_phys
             || ext_req_noctx != exp_noctx) sb_bad++;
         nreq++;
      end
   end

   always @(posedge clk) if (cyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0; reg_addr = 3'd4;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk); reg_addr = a; #1 v = reg_rdata; reg_addr = 3'd4;
   endtask

   task automatic clear_logs();
      nreq = 0; rp = 0; nwr = 0; sb_bad = 0;
   endtask

   task automatic setup(input logic [31:0] lo, input logic [15:0] hi, input logic [15:0] loff,
                        input logic [31:0] xoff, input logic [1:0] tgt, input logic ph, input logic nc);
      exp_tgt = tgt; exp_phys = ph; exp_noctx = nc;
      wr(3'd0, lo); wr(3'd1, {16'h0, hi}); wr(3'd2, {16'h0, loff}); wr(3'd3, xoff);
      wr(3'd5, {29'h0, ph, tgt}); wr(3'd6, {31'h0, nc});
   endtask

   task automatic wait_writes(input int n);
      for (int i = 0; i < 3000 && nwr < n; i++) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   task automatic check_chunk(input logic [31:0] lo, input logic [15:0] hi, input logic [15:0] loff,
                              input logic [31:0] xoff, input logic im, input logic sc, input bit chk_idle);
      int ba = 0, bw = 0, bd = 0, bs = 0, bt = 0, bi = 0, br = 0;
      logic [31:0] v;
      for (int k = 0; k < 64; k++) begin
         logic [55:0] ea;
         ea = {hi, lo, 8'h00} + 56'(xoff) + 56'(4 * k);
         if (reqlog[k] != ea) ba++;
         if (wa[k] != {loff[15:8], 8'h00} + 16'(4 * k)) bw++;
         if (wd[k] != fdat(ea)) bd++;
         if (ws[k] != sc) bs++;
         if (wt[k] != (im ? xoff : 32'h0)) bt++;
         if (wi[k] != im || wboth[k]) br++;
         if (widle[k] != (k == 63)) bi++;
      end
      chk(nreq == 64, "R2 request count", nreq, 64);
      chk(ba == 0, "R2 request addresses", ba, 0);
      chk(nwr == 64, "R3 write count", nwr, 64);
      chk(bw == 0 && bd == 0, "R3 write address/data", bw + bd, 0);
      chk(br == 0, "R3 target RAM select", br, 0);
      chk(bs == 0, "R4 secure flag", bs, 0);
      chk(bt == 0, "R5 page tag", bt, 0);
      chk(sb_bad == 0, "R9 R10 request sideband", sb_bad, 0);
      if (chk_idle) chk(bi == 0, "R6 idle at write strobes", bi, 0);
      rd(3'd4, v);
      chk(v[0] == 1'b1, "R6 idle after chunk", v[0], 1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(3'd4, v);
      chk(v[1:0] == 2'b01, "R1 command reg after reset", v[1:0], 2'b01);
      chk(!ext_req_valid && !lmem_imem_we && !lmem_dmem_we, "R1 quiet after reset",
          {ext_req_valid, lmem_imem_we, lmem_dmem_we}, 0);
   endtask

   task automatic run_chunk(input logic [31:0] lo, input logic [15:0] hi, input logic [15:0] loff,
                            input logic [31:0] xoff, input logic im, input logic sc,
                            input logic [1:0] tgt, input logic ph, input logic nc, input int rm, input int sm);
      rdy_mode = rm; rsp_mode = sm;
      setup(lo, hi, loff, xoff, tgt, ph, nc);
      clear_logs();
      wr(3'd4, {26'h0, sc, im, 4'h6});
      #1 chk(reg_rdata[0] == 1'b0, "R6 idle drops after command", reg_rdata[0], 0);
      wait_writes(64);
      check_chunk(lo, hi, loff, xoff, im, sc, 1'b1);
   endtask

   task automatic t_bad_size();
      logic [31:0] v;
      clear_logs();
      wr(3'd4, {26'h0, 2'b00, 4'h5});
      repeat (50) @(negedge clk);
      rd(3'd4, v);
      chk(nreq == 0, "R7 no request on bad size", nreq, 0);
      chk(v[1:0] == 2'b11, "R7 idle and error on bad size", v[1:0], 2'b11);
   endtask

   task automatic t_drst();
      logic [31:0] v;
      wr(3'd6, 32'h1);
      rd(3'd6, v);
      chk(v[0] == 1'b1 && ext_req_noctx, "R10 no-context bit set", {v[0], ext_req_noctx}, 2'b11);
      wr(3'd7, 32'h1);
      rd(3'd6, v);
      chk(v[0] == 1'b0 && !ext_req_noctx, "R10 control back to default", {v[0], ext_req_noctx}, 0);
      rd(3'd4, v);
      chk(v[1] == 1'b0, "R10 error cleared by DMA reset", v[1], 0);
   endtask

   task automatic t_bad_target();
      logic [31:0] v;
      wr(3'd5, 32'h3);
      clear_logs();
      wr(3'd4, 32'h06);
      repeat (50) @(negedge clk);
      rd(3'd4, v);
      chk(nreq == 0, "R9 no request with aperture 3", nreq, 0);
      chk(v[1:0] == 2'b11, "R9 error with aperture 3", v[1:0], 2'b11);
      wr(3'd7, 32'h1);
   endtask

   task automatic t_busy_cmd();
      logic [31:0] v;
      rdy_mode = 1; rsp_mode = 1;
      setup(32'h0000_4400, 16'h0012, 16'h0300, 32'h0000_0800, 2'd1, 1'b0, 1'b0);
      clear_logs();
      wr(3'd4, 32'h06);
      repeat (10) @(negedge clk);
      wr(3'd4, 32'h36);
      wait_writes(64);
      check_chunk(32'h0000_4400, 16'h0012, 16'h0300, 32'h0000_0800, 1'b0, 1'b0, 1'b0);
      rd(3'd4, v);
      chk(v[1] == 1'b1, "R8 error after command while busy", v[1], 1);
      wr(3'd7, 32'h1);
   endtask

   initial begin
      exp_tgt = 2'd0; exp_phys = 1'b0; exp_noctx = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      run_chunk(32'h0000_1000, 16'h0000, 16'h0400, 32'h0000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 0, 0);
      run_chunk(32'hFFFF_FF00, 16'hABCD, 16'h1234, 32'h0000_0300, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 1, 1);
      run_chunk(32'h0123_4500, 16'h0007, 16'hFF00, 32'h0001_0100, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 0, 1);
      t_bad_size();
      t_drst();
      t_bad_target();
      t_busy_cmd();
      run_chunk(32'h0000_0200, 16'h0001, 16'h0000, 32'h0000_0000, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule